// File: doc/BRIEF.md
# Dual-Slope Biased Differential Comparator

This block is the per-phase decision stage of a current differential protection scheme. Each accepted sample carries two unsigned magnitudes: the differential (operate) current and the bias (restraint) current. The block compares the differential current against a threshold that starts at a minimum pick-up level and rises with bias. Below a programmable knee the threshold rises along a shallow slope. Above the knee it rises along a steep slope, and the two segments meet at the knee. The block raises a start flag when the differential current lies strictly above that threshold.

Beside the restrained path sits an unrestrained high-set comparator. It looks only at the differential current against its own level. It can fire only while inrush restraint is enabled, because that is when the restrained path may be slowed by harmonic blocking. Upstream logic supplies the magnitudes. Phasor estimation and harmonic detection are not part of this block.

The block is a three-stage registered pipeline. A sample and all of its settings are captured together on `in_valid`. The result appears with `out_valid` exactly three cycles later, and a new sample may be accepted on every cycle.

Top module: `bias_diff_cmp`

## Requirements
- R1: While reset is applied and until the first result, `out_valid`, `start_flag` and `hs_flag` are low.
- R2: For every cycle in which `in_valid` is high, `out_valid` is high exactly three clock cycles later, once, and it is low in every other cycle. Samples may arrive on back-to-back cycles.
- R3: Slopes are unsigned 8-bit fractions of 256, so a slope code k means k/256. When `bias_mag` is below `set_knee`, `start_flag` is high exactly when 256·diff > k_lo·bias + 256·pickup.
- R4: When `bias_mag` is above `set_knee`, `start_flag` is high exactly when 256·diff > k_hi·bias − (k_hi − k_lo)·knee + 256·pickup.
- R5: A bias equal to `set_knee` uses the low-slope rule of R3. The threshold is continuous across the knee.
- R6: `start_flag` is never high for a sample whose diff is less than or equal to `set_pickup`, whatever the bias.
- R7: `hs_flag` is high exactly when `inrush_en` is high and diff > `set_hs_level`, with no dependence on bias or on the slope settings.
- R8: When `inrush_en` is low for a sample, `hs_flag` is low for that sample, even at full-scale diff.
- R9: Settings are used only from the cycle in which `in_valid` is high. Changing them on later cycles while `in_valid` is low does not change the result of a sample already in flight.
- R10: `start_flag` and `hs_flag` are low in any cycle in which `out_valid` is low.
- R11: All products and sums are kept at full width. Full-scale currents with full-scale settings give the results the formulas of R3 and R4 give over the integers, with no wrap-around.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_valid | input | 1 | Sample and settings are captured in this cycle |
| diff_mag | input | 16 | Differential current magnitude |
| bias_mag | input | 16 | Bias current magnitude |
| set_pickup | input | 16 | Minimum differential pick-up |
| set_knee | input | 16 | Bias level where the slope changes |
| set_slope_lo | input | 8 | Low slope, code/256 |
| set_slope_hi | input | 8 | High slope, code/256 |
| set_hs_level | input | 16 | Unrestrained high-set level |
| inrush_en | input | 1 | Inrush restraint enabled; gates the high-set path |
| out_valid | output | 1 | Result valid, three cycles after `in_valid` |
| start_flag | output | 1 | Restrained differential start |
| hs_flag | output | 1 | Unrestrained high-set start |

## Verification
Directed samples sit one least-significant step either side of the threshold on each segment. This separates a strict from a non-strict compare and a wrong slope from a right one. Samples at the knee and one step above it show which segment is chosen and that the two segments meet. Full-scale currents and settings expose any truncated product or sum, and high-set samples taken with inrush restraint on and off separate the gating from the level compare. A long stream of random samples with random gaps, with settings scrambled on idle cycles, checks the fixed latency and shows that settings are captured with their sample.

// File: rtl/bdc_pkg.sv
package bdc_pkg;
  parameter int unsigned CUR_W   = 16;
  parameter int unsigned SLOPE_W = 8;
  parameter int unsigned N_LANES = 2;   // lane 0: below-knee part, lane 1: above-knee part
  parameter int unsigned LATENCY = 3;

  localparam int unsigned PROD_W = CUR_W + SLOPE_W;
  localparam int unsigned THR_W  = PROD_W + 2;
endpackage

// File: rtl/bdc_seg_select.sv
module bdc_seg_select
  import bdc_pkg::*;
#(
  parameter int unsigned CW = CUR_W,
  parameter int unsigned SW = SLOPE_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic [CW-1:0]            diff_i,
  input  logic [CW-1:0]            bias_i,
  input  logic [CW-1:0]            pickup_i,
  input  logic [CW-1:0]            knee_i,
  input  logic [SW-1:0]            slope_lo_i,
  input  logic [SW-1:0]            slope_hi_i,
  input  logic [CW-1:0]            hs_level_i,
  input  logic                     inrush_en_i,
  output logic                     v_q,
  output logic [CW-1:0]            diff_q,
  output logic [CW-1:0]            pickup_q,
  output logic [N_LANES-1:0][CW-1:0] opnd_q,
  output logic [N_LANES-1:0][SW-1:0] slope_q,
  output logic                     hs_hit_q
);
  logic                      above_knee;
  logic [N_LANES-1:0][CW-1:0] opnd_d;
  logic [N_LANES-1:0][SW-1:0] slope_d;
  logic                      hs_hit_d;

  // Split bias into a part under the knee and a part above it.
  always_comb begin
    above_knee = bias_i > knee_i;
    if (above_knee) begin
      opnd_d[0] = knee_i;
      opnd_d[1] = bias_i - knee_i;
    end else begin
      opnd_d[0] = bias_i;
      opnd_d[1] = '0;
    end
    slope_d[0] = slope_lo_i;
    slope_d[1] = slope_hi_i;
    hs_hit_d   = inrush_en_i && (diff_i > hs_level_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q <= 1'b0;
    end else begin
      v_q <= in_valid;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      diff_q   <= '0;
      pickup_q <= '0;
      opnd_q   <= '0;
      slope_q  <= '0;
      hs_hit_q <= 1'b0;
    end else if (in_valid) begin
      diff_q   <= diff_i;
      pickup_q <= pickup_i;
      opnd_q   <= opnd_d;
      slope_q  <= slope_d;
      hs_hit_q <= hs_hit_d;
    end
  end

  // The two bias parts always add back to the captured bias.
  AST_BIAS_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
    v_q |-> ({1'b0, opnd_q[0]} + {1'b0, opnd_q[1]}) == {1'b0, $past(bias_i)}); // R4
  // At or below the knee nothing goes to the steep lane.
  AST_KNEE_LOW_SEG: assert property (@(posedge clk) disable iff (!rst_n)
    (v_q && ($past(bias_i) <= $past(knee_i))) |-> (opnd_q[1] == '0)); // R5
endmodule

// File: rtl/bdc_slope_mult.sv
module bdc_slope_mult
  import bdc_pkg::*;
#(
  parameter int unsigned CW = CUR_W,
  parameter int unsigned SW = SLOPE_W,
  localparam int unsigned PW = CW + SW
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       v_i,
  input  logic [CW-1:0]              diff_i,
  input  logic [CW-1:0]              pickup_i,
  input  logic [N_LANES-1:0][CW-1:0] opnd_i,
  input  logic [N_LANES-1:0][SW-1:0] slope_i,
  input  logic                       hs_hit_i,
  output logic                       v_q,
  output logic [CW-1:0]              diff_q,
  output logic [CW-1:0]              pickup_q,
  output logic [N_LANES-1:0][PW-1:0] prod_q,
  output logic                       hs_hit_q
);
  logic [N_LANES-1:0][PW-1:0] prod_d;

  for (genvar g = 0; g < N_LANES; g++) begin : g_lane
    always_comb begin
      prod_d[g] = PW'(opnd_i[g]) * PW'(slope_i[g]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prod_q[g] <= '0;
      end else if (v_i) begin
        prod_q[g] <= prod_d[g];
      end
    end

    // A zero slope or zero operand must give a zero product (full-width multiply).
    AST_ZERO_PRODUCT: assert property (@(posedge clk) disable iff (!rst_n)
      (v_q && (($past(opnd_i[g]) == '0) || ($past(slope_i[g]) == '0))) |-> (prod_q[g] == '0)); // R11
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q <= 1'b0;
    end else begin
      v_q <= v_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      diff_q   <= '0;
      pickup_q <= '0;
      hs_hit_q <= 1'b0;
    end else if (v_i) begin
      diff_q   <= diff_i;
      pickup_q <= pickup_i;
      hs_hit_q <= hs_hit_i;
    end
  end
endmodule

// File: rtl/bdc_decide.sv
module bdc_decide
  import bdc_pkg::*;
#(
  parameter int unsigned CW = CUR_W,
  parameter int unsigned SW = SLOPE_W,
  localparam int unsigned PW = CW + SW,
  localparam int unsigned TW = PW + 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       v_i,
  input  logic [CW-1:0]              diff_i,
  input  logic [CW-1:0]              pickup_i,
  input  logic [N_LANES-1:0][PW-1:0] prod_i,
  input  logic                       hs_hit_i,
  output logic                       v_q,
  output logic                       start_q,
  output logic                       hs_q
);
  logic [TW-1:0] thr;
  logic [TW-1:0] diff_scaled;
  logic          start_d;
  logic          hs_d;

  always_comb begin
    thr = TW'({pickup_i, {SW{1'b0}}});
    for (int i = 0; i < N_LANES; i++) begin
      thr = thr + TW'(prod_i[i]);
    end
    diff_scaled = TW'({diff_i, {SW{1'b0}}});
    start_d     = v_i && (diff_scaled > thr);
    hs_d        = v_i && hs_hit_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q     <= 1'b0;
      start_q <= 1'b0;
      hs_q    <= 1'b0;
    end else begin
      v_q     <= v_i;
      start_q <= start_d;
      hs_q    <= hs_d;
    end
  end

  AST_FLAGS_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    !v_q |-> (!start_q && !hs_q)); // R10
  AST_NO_START_AT_PICKUP: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |-> ($past(diff_i) > $past(pickup_i))); // R6
endmodule

// File: rtl/bias_diff_cmp.sv
module bias_diff_cmp
  import bdc_pkg::*;
#(
  parameter int unsigned CW = CUR_W,
  parameter int unsigned SW = SLOPE_W,
  localparam int unsigned PW = CW + SW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [CW-1:0] diff_mag,
  input  logic [CW-1:0] bias_mag,
  input  logic [CW-1:0] set_pickup,
  input  logic [CW-1:0] set_knee,
  input  logic [SW-1:0] set_slope_lo,
  input  logic [SW-1:0] set_slope_hi,
  input  logic [CW-1:0] set_hs_level,
  input  logic          inrush_en,
  output logic          out_valid,
  output logic          start_flag,
  output logic          hs_flag
);
  // Reset synchronizer: assert asynchronously, release on the clock.
  logic [1:0] rst_pipe;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_n_s = rst_pipe[1];

  logic                       s1_v, s1_hs;
  logic [CW-1:0]              s1_diff, s1_pickup;
  logic [N_LANES-1:0][CW-1:0] s1_opnd;
  logic [N_LANES-1:0][SW-1:0] s1_slope;

  logic                       s2_v, s2_hs;
  logic [CW-1:0]              s2_diff, s2_pickup;
  logic [N_LANES-1:0][PW-1:0] s2_prod;

  bdc_seg_select #(.CW(CW), .SW(SW)) u_seg (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .in_valid    (in_valid),
    .diff_i      (diff_mag),
    .bias_i      (bias_mag),
    .pickup_i    (set_pickup),
    .knee_i      (set_knee),
    .slope_lo_i  (set_slope_lo),
    .slope_hi_i  (set_slope_hi),
    .hs_level_i  (set_hs_level),
    .inrush_en_i (inrush_en),
    .v_q         (s1_v),
    .diff_q      (s1_diff),
    .pickup_q    (s1_pickup),
    .opnd_q      (s1_opnd),
    .slope_q     (s1_slope),
    .hs_hit_q    (s1_hs)
  );

  bdc_slope_mult #(.CW(CW), .SW(SW)) u_mult (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .v_i      (s1_v),
    .diff_i   (s1_diff),
    .pickup_i (s1_pickup),
    .opnd_i   (s1_opnd),
    .slope_i  (s1_slope),
    .hs_hit_i (s1_hs),
    .v_q      (s2_v),
    .diff_q   (s2_diff),
    .pickup_q (s2_pickup),
    .prod_q   (s2_prod),
    .hs_hit_q (s2_hs)
  );

  bdc_decide #(.CW(CW), .SW(SW)) u_dec (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .v_i      (s2_v),
    .diff_i   (s2_diff),
    .pickup_i (s2_pickup),
    .prod_i   (s2_prod),
    .hs_hit_i (s2_hs),
    .v_q      (out_valid),
    .start_q  (start_flag),
    .hs_q     (hs_flag)
  );

  // Cycles since reset release, saturating; keeps $past checks inside history.
  logic [1:0] age_q;
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      age_q <= 2'd0;
    end else if (age_q != 2'd3) begin
      age_q <= age_q + 2'd1;
    end
  end

  AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (!rst_n_s)
    (age_q == 2'd3) |-> (out_valid == $past(in_valid, 3))); // R2
  AST_HS_GATED: assert property (@(posedge clk) disable iff (!rst_n_s)
    ((age_q == 2'd3) && !$past(inrush_en, 3)) |-> !hs_flag); // R8
  AST_HS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n_s)
    ((age_q == 2'd3) && hs_flag) |-> ($past(diff_mag, 3) > $past(set_hs_level, 3))); // R7
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n_s |=> (!out_valid && !start_flag && !hs_flag)); // R1
endmodule

// File: tb/bias_diff_cmp_tb_top.sv
module bias_diff_cmp_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [15:0] diff_mag, bias_mag, set_pickup, set_knee, set_hs_level;
  logic [7:0]  set_slope_lo, set_slope_hi;
  logic        inrush_en;
  logic        out_valid, start_flag, hs_flag;

  always #(CLK_PERIOD/2) clk = ~clk;

  bias_diff_cmp dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .diff_mag(diff_mag), .bias_mag(bias_mag), .set_pickup(set_pickup),
    .set_knee(set_knee), .set_slope_lo(set_slope_lo), .set_slope_hi(set_slope_hi),
    .set_hs_level(set_hs_level), .inrush_en(inrush_en),
    .out_valid(out_valid), .start_flag(start_flag), .hs_flag(hs_flag)
  );

  typedef struct {
    bit    st;
    bit    hs;
    int    cyc;
    string tag;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   fails  = 0;
  int   cyc    = 0;
  bit   monitor_on = 1'b0;
  bit   done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Reference from the requirement formulas, signed integer arithmetic.
  function automatic bit ref_start(longint d, longint b, longint p, longint kn,
                                   longint kl, longint kh);
    longint thr;
    if (b <= kn) thr = kl * b + p * 256;
    else         thr = kh * b - (kh - kl) * kn + p * 256;
    return (d * 256) > thr;
  endfunction

  task automatic send(input int d, input int b, input int p, input int kn,
                      input int kl, input int kh, input int hl, input bit ie,
                      input string tag);
    exp_t e;
    @(negedge clk);
    in_valid = 1'b1; diff_mag = 16'(d); bias_mag = 16'(b); set_pickup = 16'(p);
    set_knee = 16'(kn); set_slope_lo = 8'(kl); set_slope_hi = 8'(kh);
    set_hs_level = 16'(hl); inrush_en = ie;
    e.st  = ref_start(d, b, p, kn, kl, kh);
    e.hs  = ie && (d > hl);
    e.cyc = cyc;
    e.tag = tag;
    q.push_back(e);
  endtask

  // Idle cycle with scrambled inputs; none of it may reach a result.
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      diff_mag = 16'($urandom); bias_mag = 16'($urandom);
      set_pickup = 16'($urandom); set_knee = 16'($urandom);
      set_slope_lo = 8'($urandom); set_slope_hi = 8'($urandom);
      set_hs_level = 16'($urandom); inrush_en = 1'($urandom);
    end
  endtask

  // Monitor / scoreboard.
  always @(negedge clk) begin
    if (monitor_on) begin
      if (out_valid) begin
        if (q.size() == 0) begin
          check(1'b0, "R2", "unexpected out_valid, queue depth", 0, 1);
        end else begin
          exp_t e;
          e = q.pop_front();
          check(cyc == e.cyc + 3, "R2", "latency", cyc - e.cyc, 3);
          check(start_flag == e.st, e.tag, "start_flag", start_flag, e.st);
          check(hs_flag == e.hs, e.tag, "hs_flag", hs_flag, e.hs);
        end
      end else begin
        if (start_flag || hs_flag)
          check(1'b0, "R10", "flags while not valid", {start_flag, hs_flag}, 0);
        if (q.size() != 0 && cyc > q[0].cyc + 3)
          check(1'b0, "R2", "missing out_valid, cycles waited", cyc - q[0].cyc, 3);
      end
    end
  end

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    while (!done && cyc < WATCHDOG) @(posedge clk);
    if (!done) begin
      check(1'b0, "WDOG", "watchdog expired at cycle", cyc, WATCHDOG);
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; diff_mag = '0; bias_mag = '0; set_pickup = '0;
    set_knee = '0; set_slope_lo = '0; set_slope_hi = '0; set_hs_level = '0; inrush_en = 1'b0;
    repeat (3) @(negedge clk);
    // R1: quiet during reset
    check(!out_valid && !start_flag && !hs_flag, "R1", "outputs in reset",
          {out_valid, start_flag, hs_flag}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: quiet after release, before any sample
    check(!out_valid && !start_flag && !hs_flag, "R1", "outputs after release",
          {out_valid, start_flag, hs_flag}, 0);
    monitor_on = 1'b1;

    // R3: low segment, threshold diff 200 (pickup 100, slope 64/256, bias 400)
    send(201, 400, 100, 1000, 64, 192, 65535, 1'b1, "R3");
    send(200, 400, 100, 1000, 64, 192, 65535, 1'b1, "R3");
    // R4: high segment, threshold diff 1100 at bias 2000
    send(1101, 2000, 100, 1000, 64, 192, 65535, 1'b1, "R4");
    send(1100, 2000, 100, 1000, 64, 192, 65535, 1'b1, "R4");
    // R4: shallow high slope below low slope still positive threshold
    send(300, 3000, 100, 1000, 200, 10, 65535, 1'b0, "R4");
    // R5: at the knee (threshold 350) and one step above (350.75)
    send(351, 1000, 100, 1000, 64, 192, 65535, 1'b1, "R5");
    send(350, 1000, 100, 1000, 64, 192, 65535, 1'b1, "R5");
    send(351, 1001, 100, 1000, 64, 192, 65535, 1'b1, "R5");
    send(350, 1001, 100, 1000, 64, 192, 65535, 1'b1, "R5");
    // R6: diff equal to pickup never starts; one above does at zero slope
    send(100, 0, 100, 1000, 0, 0, 65535, 1'b0, "R6");
    send(101, 0, 100, 1000, 0, 0, 65535, 1'b0, "R6");
    // R7: high-set level compare, independent of bias
    send(5001, 0, 60000, 0, 255, 255, 5000, 1'b1, "R7");
    send(5000, 0, 0, 0, 0, 0, 5000, 1'b1, "R7");
    send(5001, 60000, 0, 100, 255, 255, 5000, 1'b1, "R7");
    // R8: inrush restraint off forces high-set low
    send(65535, 0, 0, 0, 0, 0, 0, 1'b0, "R8");
    // R11: full-scale values
    send(65535, 65535, 65535, 0, 255, 255, 0, 1'b1, "R11");
    send(65535, 65535, 0, 0, 0, 255, 65534, 1'b1, "R11");
    send(65535, 65535, 65535, 65535, 255, 255, 65535, 1'b1, "R11");
    // R9: settings scrambled on idle cycles after a sample
    send(201, 400, 100, 1000, 64, 192, 150, 1'b1, "R9");
    idle(3);
    send(200, 400, 100, 1000, 64, 192, 250, 1'b1, "R9");
    idle(5);
    // R2: random stream with random gaps
    for (int n = 0; n < 400; n++) begin
      int kn;
      kn = $urandom_range(0, 65535);
      send($urandom_range(0, 65535), $urandom_range(0, 65535),
           $urandom_range(0, 4000), kn, $urandom_range(0, 128),
           $urandom_range(64, 255), $urandom_range(0, 65535), 1'($urandom), "R2");
      if ($urandom_range(0, 3) == 0) idle($urandom_range(1, 3));
    end
    idle(8);
    check(q.size() == 0, "R2", "results outstanding", q.size(), 0);
    done = 1'b1;
    finish_run();
  end
endmodule